// File: doc/BRIEF.md
# Stack Frame Save/Restore Sequencer

This block carries out a compressed-instruction frame SAVE or RESTORE over several cycles. The instruction decoder passes in the fields it has decoded: a save/restore select, a short/extended form flag, three single-register flags (return address, s0, s1), a count of extra static registers, a 4-bit argument-register code and a frame-size field. The sequencer reads the stack pointer (register 29) from the register file when it starts. It then walks a fixed ordering of candidate registers. For each one it makes one word access through a request/acknowledge memory port and one register-file read or write.

A save first stores the non-static argument registers upward from the stack pointer. It then stores the rest downward from the old stack pointer, decrementing the address by 4 before each store. A restore loads the same registers in the same order, counting down from the stack pointer plus the frame size. At the end the stack pointer is moved by the frame size and a one-cycle completion pulse follows. The reserved argument code raises an exception pulse, and nothing is read from memory, written to memory or written to the register file.

Top module: `stack_frame_seq`

## Requirements
- R1: The argument code gives the non-static argument count: codes 0,1,2,3,11 give 0; 4..7 give 1; 8,9,10 give 2; 12,13 give 3; 14 gives 4. Code 15 in the extended form makes `exc_o` high for exactly the cycle after the accepted start, with no memory request, no register-file write and no `done_o`.
- R2: The argument code gives the static argument count: codes 0,4,8,12,14 give 0; 1,5,9,13 give 1; 2,6,10 give 2; 3,7 give 3; 11 gives 4.
- R3: A save first stores argument registers r4, r5, … (as many as the non-static count) at SP+0, SP+4, SP+8, SP+12. Register r4 goes to SP+0.
- R4: After that come the remaining accesses. Each uses an address one word (4 bytes) below the previous one, starting 4 below the base. They go in this order: r31 if the return-address flag is set; the last N of the list r30,r23,r22,r21,r20,r19,r18, where N is the extra-static count (1..7); r17 if the s1 flag is set; r16 if the s0 flag is set; then r7,r6,r5,r4, as many as the static count. For a save the base is the old SP.
- R5: A save ends by writing SP−framesize to r29. `done_o` is high for exactly the one cycle after that write.
- R6: A restore uses base SP+framesize and the order of R4. It writes each loaded word to its register, never touches the non-static argument registers, ends by writing SP+framesize to r29, and then pulses `done_o`.
- R7: Short form (`ext_i`=0): framesize is `frame_lo_i`×8, with 0 meaning 128. The extra-static count and the argument code are taken as zero, whatever their inputs carry.
- R8: Extended form: framesize is the 8-bit value {`frame_hi_i`,`frame_lo_i`}×8.
- R9: At most one memory request is outstanding. Address, data and direction stay stable until `mem_ack_i`, and the sequence advances only on an acknowledge. A memory request and a register-file write never occur in the same cycle.
- R10: `start_i` is ignored while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled only when idle) |
| save_i | input | 1 | 1 = save, 0 = restore |
| ext_i | input | 1 | 1 = extended form |
| ra_i | input | 1 | Include r31 |
| s0_i | input | 1 | Include r16 |
| s1_i | input | 1 | Include r17 |
| xs_cnt_i | input | 3 | Extra static register count (extended form) |
| arg_code_i | input | 4 | Argument register code (extended form) |
| frame_hi_i | input | 4 | Frame field upper nibble (extended form) |
| frame_lo_i | input | 4 | Frame field lower nibble |
| rf_addr_o | output | 5 | Register-file address for read or write |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wdata_o | output | XLEN | Register-file write data |
| rf_rdata_i | input | XLEN | Register-file read data (combinational from rf_addr_o) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory direction, 1 = store |
| mem_addr_o | output | XLEN | Memory byte address |
| mem_wdata_o | output | XLEN | Store data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | XLEN | Load data, valid with the acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| exc_o | output | 1 | One-cycle reserved-code exception pulse |

## Verification
The assertions assume three things about the inputs. The stack pointer in r29 is word aligned. The memory returns `mem_ack_i` only while a request is pending. The register file answers reads within the same cycle. The bench keeps to these assumptions: it sets r29 to an aligned address before each operation, models a memory that raises an acknowledge only after it sees a request and drops it the cycle after, and models a register file with combinational reads. Acknowledge latencies from zero to three wait cycles exercise the hold-until-acknowledge behaviour.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int NSLOT   = 18;
  localparam int SLOT_W  = 5;
  localparam int NARG    = 4;
  localparam int NXS     = 7;
  localparam int SLOT_RA = 4;
  localparam int SLOT_XS = 5;
  localparam int SLOT_S1 = 12;
  localparam int SLOT_S0 = 13;
  localparam int SLOT_ST = 14;
  localparam logic [4:0] REG_SP = 5'd29;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PICK, ST_MEM, ST_WB, ST_SP, ST_DONE, ST_EXC
  } seq_state_t;

  // slot index -> architectural register
  function automatic logic [4:0] slot_reg(input logic [SLOT_W-1:0] s);
    if (s < 5'd4)       return 5'(5'd4 + s);
    else if (s == 5'd4) return 5'd31;
    else if (s == 5'd5) return 5'd30;
    else if (s < 5'd14) return 5'(5'd29 - s);
    else                return 5'(5'd21 - s);
  endfunction
endpackage

// File: rtl/sfs_code_dec.sv
module sfs_code_dec (
  input  logic [3:0] code_i,
  output logic [2:0] arg_cnt_o,
  output logic [2:0] st_cnt_o,
  output logic       bad_o
);
  always_comb begin
    bad_o = 1'b0;
    unique case (code_i)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd11: arg_cnt_o = 3'd0;
      4'd4, 4'd5, 4'd6, 4'd7:        arg_cnt_o = 3'd1;
      4'd8, 4'd9, 4'd10:             arg_cnt_o = 3'd2;
      4'd12, 4'd13:                  arg_cnt_o = 3'd3;
      4'd14:                         arg_cnt_o = 3'd4;
      default: begin arg_cnt_o = 3'd0; bad_o = 1'b1; end
    endcase
    unique case (code_i)
      4'd1, 4'd5, 4'd9, 4'd13: st_cnt_o = 3'd1;
      4'd2, 4'd6, 4'd10:       st_cnt_o = 3'd2;
      4'd3, 4'd7:              st_cnt_o = 3'd3;
      4'd11:                   st_cnt_o = 3'd4;
      default:                 st_cnt_o = 3'd0;
    endcase
  end

  // argument registers are shared between the two groups: never more than four
  always_comb begin
    p_arg_budget_r2: assert (bad_o || (4'(arg_cnt_o) + 4'(st_cnt_o) <= 4'd4))
      else $error("argument and static counts exceed four");
  end
endmodule

// File: rtl/sfs_frame_calc.sv
module sfs_frame_calc #(
  parameter int XLEN = 32
) (
  input  logic            ext_i,
  input  logic [3:0]      hi_i,
  input  logic [3:0]      lo_i,
  output logic [XLEN-1:0] frame_o
);
  logic [7:0] units;

  always_comb begin
    if (ext_i)              units = {hi_i, lo_i};
    else if (lo_i == 4'd0)  units = 8'd16;
    else                    units = {4'd0, lo_i};
    frame_o = XLEN'({units, 3'b000});
  end
endmodule

// File: rtl/sfs_slot_mask.sv
module sfs_slot_mask
  import sfs_pkg::*;
(
  input  logic             save_i,
  input  logic             ra_i,
  input  logic             s0_i,
  input  logic             s1_i,
  input  logic [2:0]       xs_cnt_i,
  input  logic [2:0]       arg_cnt_i,
  input  logic [2:0]       st_cnt_i,
  output logic [NSLOT-1:0] mask_o
);
  for (genvar i = 0; i < NARG; i++) begin : g_arg
    assign mask_o[i] = save_i && (int'(arg_cnt_i) > i);
  end
  assign mask_o[SLOT_RA] = ra_i;
  // extra statics fill from the bottom of the list (r18) upward
  for (genvar j = 0; j < NXS; j++) begin : g_xs
    assign mask_o[SLOT_XS+j] = (int'(xs_cnt_i) + j >= NXS);
  end
  assign mask_o[SLOT_S1] = s1_i;
  assign mask_o[SLOT_S0] = s0_i;
  for (genvar k = 0; k < NARG; k++) begin : g_st
    assign mask_o[SLOT_ST+k] = (int'(st_cnt_i) > k);
  end
endmodule

// File: rtl/sfs_ffs.sv
module sfs_ffs #(
  parameter int N = 18,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
  import sfs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            save_i,
  input  logic            ext_i,
  input  logic            ra_i,
  input  logic            s0_i,
  input  logic            s1_i,
  input  logic [2:0]      xs_cnt_i,
  input  logic [3:0]      arg_code_i,
  input  logic [3:0]      frame_hi_i,
  input  logic [3:0]      frame_lo_i,
  output logic [4:0]      rf_addr_o,
  output logic            rf_we_o,
  output logic [XLEN-1:0] rf_wdata_o,
  input  logic [XLEN-1:0] rf_rdata_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            done_o,
  output logic            exc_o
);
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  seq_state_t        state_q;
  logic [NSLOT-1:0]  mask_q, mask_new;
  logic [XLEN-1:0]   sp_q, frame_q, ptr_q, addr_q, data_q, frame_new;
  logic [4:0]        reg_q;
  logic              save_q;

  logic [2:0]        xs_eff, arg_cnt, st_cnt;
  logic [3:0]        code_eff;
  logic              code_bad;
  logic [SLOT_W-1:0] sel;
  logic              sel_any, sel_arg;

  // short form carries neither extra statics nor an argument code
  assign xs_eff   = ext_i ? xs_cnt_i   : 3'd0;
  assign code_eff = ext_i ? arg_code_i : 4'd0;

  sfs_code_dec u_dec (
    .code_i    (code_eff),
    .arg_cnt_o (arg_cnt),
    .st_cnt_o  (st_cnt),
    .bad_o     (code_bad)
  );

  sfs_frame_calc #(.XLEN(XLEN)) u_frame (
    .ext_i   (ext_i),
    .hi_i    (frame_hi_i),
    .lo_i    (frame_lo_i),
    .frame_o (frame_new)
  );

  sfs_slot_mask u_mask (
    .save_i    (save_i),
    .ra_i      (ra_i),
    .s0_i      (s0_i),
    .s1_i      (s1_i),
    .xs_cnt_i  (xs_eff),
    .arg_cnt_i (arg_cnt),
    .st_cnt_i  (st_cnt),
    .mask_o    (mask_new)
  );

  sfs_ffs #(.N(NSLOT), .W(SLOT_W)) u_ffs (
    .vec_i (mask_q),
    .idx_o (sel),
    .any_o (sel_any)
  );

  assign sel_arg = (sel < SLOT_W'(NARG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      sp_q    <= '0;
      frame_q <= '0;
      ptr_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      reg_q   <= '0;
      save_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (code_bad) begin
            state_q <= ST_EXC;
          end else begin
            sp_q    <= rf_rdata_i;
            frame_q <= frame_new;
            mask_q  <= mask_new;
            save_q  <= save_i;
            ptr_q   <= save_i ? rf_rdata_i : rf_rdata_i + frame_new;
            state_q <= ST_PICK;
          end
        end
        ST_PICK: begin
          if (!sel_any) begin
            state_q <= ST_SP;
          end else begin
            mask_q[sel] <= 1'b0;
            reg_q       <= slot_reg(sel);
            if (sel_arg) begin
              addr_q <= sp_q + XLEN'({sel[1:0], 2'b00});
            end else begin
              addr_q <= ptr_q - WORD;
              ptr_q  <= ptr_q - WORD;
            end
            if (save_q) data_q <= rf_rdata_i;
            state_q <= ST_MEM;
          end
        end
        ST_MEM: if (mem_ack_i) begin
          if (save_q) begin
            state_q <= ST_PICK;
          end else begin
            data_q  <= mem_rdata_i;
            state_q <= ST_WB;
          end
        end
        ST_WB:   state_q <= ST_PICK;
        ST_SP:   state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        ST_EXC:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rf_we_o    = 1'b0;
    rf_wdata_o = data_q;
    rf_addr_o  = reg_q;
    unique case (state_q)
      ST_IDLE: rf_addr_o = REG_SP;
      ST_PICK: rf_addr_o = slot_reg(sel);
      ST_WB:   rf_we_o   = 1'b1;
      ST_SP: begin
        rf_addr_o  = REG_SP;
        rf_we_o    = 1'b1;
        rf_wdata_o = save_q ? sp_q - frame_q : sp_q + frame_q;
      end
      default: ;
    endcase
  end

  assign mem_req_o   = (state_q == ST_MEM);
  assign mem_we_o    = save_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
  assign done_o      = (state_q == ST_DONE);
  assign exc_o       = (state_q == ST_EXC);

  // reserved code stops before any side effect
  p_bad_code_exc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && ext_i && arg_code_i == 4'd15)
      |=> (exc_o && !mem_req_o && !rf_we_o))
    else $error("reserved code did not raise a clean exception");

  p_exc_no_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> !done_o && !mem_req_o)
    else $error("exception followed by activity");

  p_addr_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00)
    else $error("unaligned word access");

  p_done_after_sp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rf_we_o && rf_addr_o == REG_SP))
    else $error("done without preceding stack pointer write");

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_wdata_o) && $stable(mem_we_o)))
    else $error("request dropped or changed before acknowledge");

  p_one_port_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rf_we_o && mem_req_o))
    else $error("register write overlaps memory request");
endmodule

// File: tb/stack_frame_seq_bench.sv
module stack_frame_seq_bench;
  localparam logic [31:0] SP0 = 32'h0000_0800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, save = 1'b0, ext = 1'b0, ra = 1'b0, s0 = 1'b0, s1 = 1'b0;
  logic [2:0]  xs = '0;
  logic [3:0]  code = '0, fhi = '0, flo = '0;
  logic [4:0]  rf_addr;
  logic        rf_we;
  logic [31:0] rf_wdata, rf_rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        done, exc;

  logic [31:0] rf_arr [0:31];
  logic [31:0] mem_arr [0:1023];

  int n_chk = 0, n_bad = 0, cyc = 0, ack_lat = 0, wcnt = 0;
  int m_n, r_n, sp_n, sp_cyc, hold_err;
  logic [31:0] m_addr [0:31];
  logic [31:0] m_data [0:31];
  logic        m_we   [0:31];
  logic [4:0]  r_reg  [0:31];
  logic [31:0] r_data [0:31];
  logic [31:0] sp_val;
  logic        pend_q = 1'b0;
  logic [31:0] pend_addr = '0;

  int          e_n;
  logic [31:0] e_addr [0:31];
  logic [31:0] e_data [0:31];
  logic [4:0]  e_reg  [0:31];
  logic [31:0] e_sp;

  stack_frame_seq u_stack_frame_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .save_i(save), .ext_i(ext),
    .ra_i(ra), .s0_i(s0), .s1_i(s1), .xs_cnt_i(xs), .arg_code_i(code),
    .frame_hi_i(fhi), .frame_lo_i(flo),
    .rf_addr_o(rf_addr), .rf_we_o(rf_we), .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .done_o(done), .exc_o(exc)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign rf_rdata = rf_arr[rf_addr];

  // memory responder and register-file model, both away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend_q && mem_req && mem_addr != pend_addr) hold_err++;
      if (mem_ack) begin
        mem_ack = 1'b0;
        pend_q = 1'b0;
      end else if (mem_req) begin
        pend_q = 1'b1;
        pend_addr = mem_addr;
        if (wcnt >= ack_lat) begin
          wcnt = 0;
          mem_ack = 1'b1;
          if (m_n < 32) begin
            m_addr[m_n] = mem_addr; m_we[m_n] = mem_we; m_data[m_n] = mem_wdata;
          end
          m_n++;
          if (mem_we) mem_arr[mem_addr[11:2]] = mem_wdata;
          else        mem_rdata = mem_arr[mem_addr[11:2]];
        end else begin
          wcnt++;
        end
      end
      if (rf_we) begin
        if (rf_addr == 5'd29) begin
          sp_n++; sp_cyc = cyc; sp_val = rf_wdata;
        end else begin
          if (r_n < 32) begin r_reg[r_n] = rf_addr; r_data[r_n] = rf_wdata; end
          r_n++;
        end
        rf_arr[rf_addr] = rf_wdata;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int arg_count(input logic [3:0] c);
    case (c)
      4'd4, 4'd5, 4'd6, 4'd7: return 1;
      4'd8, 4'd9, 4'd10:      return 2;
      4'd12, 4'd13:           return 3;
      4'd14:                  return 4;
      default:                return 0;
    endcase
  endfunction

  function automatic int static_count(input logic [3:0] c);
    case (c)
      4'd1, 4'd5, 4'd9, 4'd13: return 1;
      4'd2, 4'd6, 4'd10:       return 2;
      4'd3, 4'd7:              return 3;
      4'd11:                   return 4;
      default:                 return 0;
    endcase
  endfunction

  function automatic logic [4:0] xs_reg(input int k); // k=0 -> r18 ... k=6 -> r30
    return (k == 6) ? 5'd30 : 5'(18 + k);
  endfunction

  task automatic push(input logic [31:0] a, input logic [4:0] r, input bit sv);
    e_addr[e_n] = a; e_reg[e_n] = r;
    if (!sv) mem_arr[a[11:2]] = 32'h5A00_0000 ^ a ^ (32'(cyc) << 12);
    e_data[e_n] = sv ? rf_arr[r] : mem_arr[a[11:2]];
    e_n++;
  endtask

  // expected access list per R1..R8
  task automatic build(input bit sv, input bit rflag, input bit f0, input bit f1,
                       input logic [2:0] x, input logic [3:0] c, input bit ex,
                       input logic [3:0] h, input logic [3:0] l);
    int frame, na, ns, nx;
    logic [31:0] p;
    logic [3:0] ce;
    ce = ex ? c : 4'd0;
    nx = ex ? int'(x) : 0;
    na = arg_count(ce);
    ns = static_count(ce);
    frame = ex ? int'({h, l}) * 8 : (l == 0 ? 128 : int'(l) * 8);
    e_n = 0;
    if (sv) for (int i = 0; i < na; i++) push(SP0 + 32'(4 * i), 5'(4 + i), sv);
    p = sv ? SP0 : SP0 + 32'(frame);
    if (rflag) begin p = p - 4; push(p, 5'd31, sv); end
    for (int k = nx - 1; k >= 0; k--) begin p = p - 4; push(p, xs_reg(k), sv); end
    if (f1) begin p = p - 4; push(p, 5'd17, sv); end
    if (f0) begin p = p - 4; push(p, 5'd16, sv); end
    for (int k = 0; k < ns; k++) begin p = p - 4; push(p, 5'(7 - k), sv); end
    e_sp = sv ? SP0 - 32'(frame) : SP0 + 32'(frame);
  endtask

  task automatic run_op(input bit sv, input bit rflag, input bit f0, input bit f1,
                        input logic [2:0] x, input logic [3:0] c, input bit ex,
                        input logic [3:0] h, input logic [3:0] l, input int lat,
                        input bit poke, input string tag_ord, input string tag_sp);
    int done_cyc, t;
    rf_arr[29] = SP0;
    ack_lat = lat;
    build(sv, rflag, f0, f1, x, c, ex, h, l);
    m_n = 0; r_n = 0; sp_n = 0; hold_err = 0; done_cyc = -1;
    @(negedge clk);
    save = sv; ra = rflag; s0 = f0; s1 = f1; xs = x; code = c; ext = ex; fhi = h; flo = l;
    start = 1'b1;
    t = 0;
    while (t < 3000 && done_cyc < 0) begin
      @(posedge clk); #2;
      start = 1'b0;
      if (poke && t == 3) begin // R10: second start while busy
        save = ~sv; code = 4'd14; ext = 1'b1; ra = 1'b1; start = 1'b1;
      end
      if (done) done_cyc = cyc;
      t++;
    end
    start = 1'b0;
    @(posedge clk); #2;
    chk(tag_ord, "operation completed", 32'(done_cyc >= 0), 32'd1);
    chk(tag_ord, "memory access count", 32'(m_n), 32'(e_n));
    for (int i = 0; i < e_n && i < m_n; i++) begin
      chk(tag_ord, $sformatf("access %0d address", i), m_addr[i], e_addr[i]);
      chk(tag_ord, $sformatf("access %0d direction", i), 32'(m_we[i]), 32'(sv));
      if (sv) chk(tag_ord, $sformatf("access %0d store data", i), m_data[i], e_data[i]);
    end
    if (!sv) begin
      chk(tag_ord, "register writes", 32'(r_n), 32'(e_n));
      for (int i = 0; i < e_n && i < r_n; i++) begin
        chk(tag_ord, $sformatf("write %0d register", i), 32'(r_reg[i]), 32'(e_reg[i]));
        chk(tag_ord, $sformatf("write %0d data", i), r_data[i], e_data[i]);
      end
    end else begin
      chk(tag_ord, "no register writes on save", 32'(r_n), 32'd0);
    end
    chk(tag_sp, "one SP write", 32'(sp_n), 32'd1);
    chk(tag_sp, "final SP", sp_val, e_sp);
    chk("R5", "done one cycle after SP write", 32'(done_cyc), 32'(sp_cyc + 1));
    chk("R9", "request held until ack", 32'(hold_err), 32'd0);
  endtask

  task automatic t_reset;
    chk("R5", "done low after reset", 32'(done), 32'd0);
    chk("R1", "exc low after reset", 32'(exc), 32'd0);
    chk("R9", "no request after reset", 32'(mem_req), 32'd0);
    chk("R9", "no rf write after reset", 32'(rf_we), 32'd0);
  endtask

  task automatic t_save_full;  // R3 R4 R8
    run_op(1, 1, 1, 1, 3'd3, 4'd13, 1, 4'd1, 4'd0, 0, 0, "R3", "R5");
    run_op(1, 1, 1, 1, 3'd3, 4'd13, 1, 4'd1, 4'd0, 1, 0, "R4", "R8");
  endtask

  task automatic t_restore_full;  // R6
    logic [31:0] r4_before;
    r4_before = 32'hC0DE_0004;
    rf_arr[4] = r4_before;
    run_op(0, 1, 1, 1, 3'd3, 4'd13, 1, 4'd1, 4'd0, 1, 0, "R6", "R6");
    chk("R6", "non-static argument r4 untouched", rf_arr[4], r4_before);
    run_op(0, 0, 0, 0, 3'd0, 4'd14, 1, 4'd0, 4'd2, 0, 0, "R6", "R6");
  endtask

  task automatic t_bad_code;  // R1
    int t, seen;
    rf_arr[29] = SP0;
    m_n = 0; r_n = 0; sp_n = 0; seen = 0;
    @(negedge clk);
    save = 1; ext = 1; code = 4'd15; ra = 1; s0 = 1; xs = 3'd2; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    chk("R1", "exc raised after start", 32'(exc), 32'd1);
    for (t = 0; t < 8; t++) begin
      @(posedge clk); #2;
      if (exc || done) seen++;
    end
    chk("R1", "exc is a single pulse, no done", 32'(seen), 32'd0);
    chk("R1", "no memory access", 32'(m_n), 32'd0);
    chk("R1", "no register write", 32'(r_n + sp_n), 32'd0);
    chk("R1", "SP unchanged", rf_arr[29], SP0);
  endtask

  task automatic t_code_sweep;  // R1 R2
    for (int c = 0; c < 15; c++) begin
      run_op(1, 0, 0, 0, 3'd0, 4'(c), 1, 4'd0, 4'd1, 0, 0, "R1", "R5");
      run_op(0, 0, 0, 0, 3'd0, 4'(c), 1, 4'd0, 4'd1, 0, 0, "R2", "R6");
    end
  endtask

  task automatic t_xs_wait;  // R4 R9
    run_op(1, 1, 0, 1, 3'd7, 4'd11, 1, 4'd2, 4'd0, 3, 0, "R4", "R5");
    run_op(0, 1, 0, 1, 3'd7, 4'd11, 1, 4'd2, 4'd0, 2, 0, "R9", "R6");
  endtask

  task automatic t_short;  // R7
    run_op(1, 1, 1, 0, 3'd5, 4'd11, 0, 4'd9, 4'd0, 0, 0, "R7", "R7");
    run_op(0, 1, 1, 0, 3'd5, 4'd11, 0, 4'd9, 4'd3, 1, 0, "R7", "R7");
  endtask

  task automatic t_big_frame;  // R8
    run_op(1, 1, 0, 0, 3'd1, 4'd1, 1, 4'hF, 4'hF, 0, 0, "R8", "R8");
    run_op(0, 1, 0, 0, 3'd1, 4'd1, 1, 4'hF, 4'hF, 0, 0, "R8", "R8");
  endtask

  task automatic t_busy_start;  // R10
    run_op(1, 0, 1, 1, 3'd2, 4'd6, 1, 4'd0, 4'd4, 2, 1, "R10", "R10");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf_arr[i] = 32'hA000_0000 + 32'(i);
    for (int i = 0; i < 1024; i++) mem_arr[i] = '0;
    repeat (3) @(posedge clk);
    #2 t_reset;
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_save_full;
    t_restore_full;
    t_bad_code;
    t_code_sweep;
    t_xs_wait;
    t_short;
    t_big_frame;
    t_busy_start;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule